// File: doc/BRIEF.md
# Startup Configuration Register with Timed Single-Write Protection

This block holds the two startup configuration controls of a small 8-bit microcontroller: a watchdog-disable bit and a ROM-enable bit. Software may change them only early after reset. In the normal operating modes (single-chip or expanded), a write is accepted only while fewer than 64 bus cycles have passed since reset. Only the first accepted write counts. After that the register stays locked until the next reset.

In the special operating modes (bootstrap or test), both gates are bypassed and the register can be rewritten at any time. A mode-select bit can drop the part from special to normal. From that point on, the normal-mode rules apply. The reset values depend on the strapped mode. The bus is a plain single-cycle register interface: a bus-cycle strobe, an address, a write enable and write data. Read data is returned combinationally from the address. There is no back-pressure, because every bus cycle completes in one clock.

Top module: `cfg_once_reg`

## Requirements
- R1: On reset, `rom_en` is 1 in every mode. `wdog_dis` is 0 when `boot_special` is 0, and 1 when `boot_special` is 1.
- R2: A read at address 0x3F returns `wdog_dis` in bit 2 and `rom_en` in bit 1. Bits 7..3 and bit 0 read as 0, even after a write of 1s. A read of any other address returns 0. Reads are never blocked by the protection.
- R3: Bus cycles are counted from 0 after reset. Only clocks with `bus_stb` high advance the count. In normal mode, a write at bus cycle 63 is accepted, and idle clocks without a strobe do not use up the window.
- R4: In normal mode, a write at bus cycle 64 or later is ignored.
- R5: In normal mode, only the first accepted write after reset takes effect. It locks the register even when it writes the value already held. Every later write is ignored until reset.
- R6: Special mode is `boot_special` and `smode_bit` both high. In special mode, every write to 0x3F is accepted at any bus cycle, repeatedly. With `boot_special` low, `smode_bit` has no effect.
- R7: After `smode_bit` falls, the normal-mode rules apply from the next clock. Writes made in special mode do not set the lock. A normal write is then still accepted if the window is open, and is rejected if the window has closed.
- R8: A cycle changes nothing and does not set the lock if `bus_stb` is low, `bus_we` is low, or the address is not 0x3F.
- R9: The bus-cycle count saturates. The window never reopens before the next reset, however many bus cycles pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_special | input | 1 | Strapped mode: 1 = bootstrap/test, 0 = single-chip/expanded |
| smode_bit | input | 1 | Mode-select bit; may only fall after reset |
| bus_stb | input | 1 | One bus cycle in this clock |
| bus_addr | input | 6 | Register-block offset |
| bus_we | input | 1 | Write qualifier for the bus cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| wdog_dis | output | 1 | 1 = watchdog disabled |
| rom_en | output | 1 | 1 = ROM mapped |

## Verification
The assertions assume that `boot_special` stays steady while reset is released, and that `smode_bit` can only go from 1 to 0 between resets. This matches a mode bit that software may clear but never set. The bench changes both inputs only while `rst_n` is low, with one exception: a single falling edge of `smode_bit` during the mode-drop scenario. Under these assumptions, the register-freeze properties hold: the outputs are frozen once normal mode is locked or its window has closed.

// File: rtl/cfg_once_pkg.sv
package cfg_once_pkg;

  // Build a one-hot-per-field mask of the implemented bits.
  function automatic logic [7:0] impl_mask8(input int wdog_pos, input int rom_pos);
    logic [7:0] m;
    m = '0;
    m[wdog_pos] = 1'b1;
    m[rom_pos]  = 1'b1;
    return m;
  endfunction

  typedef enum logic [1:0] {
    GATE_OPEN   = 2'b00,
    GATE_LOCKED = 2'b01,
    GATE_CLOSED = 2'b10,
    GATE_BYPASS = 2'b11
  } gate_state_e;

endpackage

// File: rtl/cfg_win_timer.sv
module cfg_win_timer #(
  parameter int WIN_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  output logic win_open
);
  localparam int CNT_W = $clog2(WIN_CYCLES) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] WIN_LIM = CNT_W'(WIN_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (stb && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign win_open = (cnt_q < WIN_LIM);

  // The window only ever closes within one reset period.
  assert_win_no_reopen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |=> !win_open);

  // Clocks without a bus cycle do not use up the window.
  assert_cnt_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(cnt_q));
endmodule

// File: rtl/cfg_gate.sv
module cfg_gate
  import cfg_once_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit_wr,
  input  logic win_open,
  input  logic special,
  output logic accept,
  output logic locked
);
  gate_state_e gstate;

  always_comb begin
    if (special)       gstate = GATE_BYPASS;
    else if (locked)   gstate = GATE_LOCKED;
    else if (!win_open) gstate = GATE_CLOSED;
    else               gstate = GATE_OPEN;
  end

  assign accept = hit_wr && (gstate == GATE_BYPASS || gstate == GATE_OPEN);

  always_ff @(posedge clk) begin
    if (!rst_n)                 locked <= 1'b0;
    else if (accept && !special) locked <= 1'b1;
  end

  // The lock is sticky until reset.
  assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // The lock only rises after a write made in normal mode.
  assert_lock_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(hit_wr && !special));
endmodule

// File: rtl/cfg_store.sv
module cfg_store
  import cfg_once_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int WDOG_POS = 2,
  parameter int ROM_POS  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_special,
  input  logic              accept,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] image
);
  localparam logic [DATA_W-1:0] MASK = DATA_W'(impl_mask8(WDOG_POS, ROM_POS));

  logic [DATA_W-1:0] rst_img;

  always_comb begin
    rst_img = '0;
    rst_img[ROM_POS]  = 1'b1;
    rst_img[WDOG_POS] = boot_special;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      image <= rst_img;
    else if (accept) image <= wdata & MASK;
  end

  // ROM is mapped after reset in every mode.
  assert_rom_after_reset_R1: assert property (@(posedge clk)
    !rst_n |=> image[ROM_POS]);

  // The image never changes without an accepted write.
  assert_hold_no_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(image));
endmodule

// File: rtl/cfg_once_reg.sv
module cfg_once_reg #(
  parameter int          ADDR_W     = 6,
  parameter int          DATA_W     = 8,
  parameter logic [5:0]  CFG_ADDR   = 6'h3F,
  parameter int          WIN_CYCLES = 64,
  parameter int          WDOG_POS   = 2,
  parameter int          ROM_POS    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_special,
  input  logic              smode_bit,
  input  logic              bus_stb,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdog_dis,
  output logic              rom_en
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CFG_ADDR);

  logic              sel;
  logic              hit_wr;
  logic              special;
  logic              win_open;
  logic              accept;
  logic              locked;
  logic [DATA_W-1:0] image;

  assign sel     = (bus_addr == MY_ADDR);
  assign hit_wr  = bus_stb && bus_we && sel;
  assign special = boot_special && smode_bit;

  cfg_win_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .stb(bus_stb), .win_open(win_open)
  );

  cfg_gate u_gate (
    .clk(clk), .rst_n(rst_n), .hit_wr(hit_wr), .win_open(win_open),
    .special(special), .accept(accept), .locked(locked)
  );

  cfg_store #(.DATA_W(DATA_W), .WDOG_POS(WDOG_POS), .ROM_POS(ROM_POS)) u_store (
    .clk(clk), .rst_n(rst_n), .boot_special(boot_special), .accept(accept),
    .wdata(bus_wdata), .image(image)
  );

  assign wdog_dis  = image[WDOG_POS];
  assign rom_en    = image[ROM_POS];
  assign bus_rdata = sel ? image : '0;

  // Input assumption: the mode-select bit can only fall between resets.
  assert_smode_only_falls_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !smode_bit |=> !smode_bit);

  // Input assumption: the strapped mode is steady outside reset.
  assert_boot_steady_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(boot_special));

  // Once locked in normal mode, the controls are frozen.
  assert_locked_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!special && locked) |=> $stable({wdog_dis, rom_en}));

  // Once the window has closed in normal mode, the controls are frozen.
  assert_closed_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!special && !win_open) |=> $stable({wdog_dis, rom_en}));
endmodule

// File: tb/cfg_once_reg_tb.sv
module cfg_once_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       boot_special = 1'b0;
  logic       smode_bit = 1'b0;
  logic       bus_stb = 1'b0;
  logic [5:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       wdog_dis, rom_en;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam logic [5:0] CFG = 6'h3F;

  always #5 clk = ~clk;

  cfg_once_reg dut_i (
    .clk(clk), .rst_n(rst_n), .boot_special(boot_special), .smode_bit(smode_bit),
    .bus_stb(bus_stb), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wdog_dis(wdog_dis), .rom_en(rom_en)
  );

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Read the register image through the bus and compare pins too.
  task automatic check_cfg(input string req, input logic [7:0] exp);
    bus_addr = CFG;
    #1;
    check8(req, bus_rdata, exp);
    check8(req, {5'b0, wdog_dis, rom_en, 1'b0}, exp);
  endtask

  task automatic do_reset(input logic boot, input logic smode);
    @(negedge clk);
    rst_n = 1'b0; boot_special = boot; smode_bit = smode;
    bus_stb = 1'b0; bus_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bus_cyc(input logic stb, input logic we, input logic [5:0] a,
                         input logic [7:0] d);
    bus_stb = stb; bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_stb = 1'b0; bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) bus_cyc(1'b1, 1'b0, 6'h00, 8'h00);
  endtask

  task automatic t_reset_values;
    do_reset(1'b0, 1'b0);
    check_cfg("R1 normal reset", 8'h02);
    bus_addr = 6'h10; #1;
    check8("R2 other addr reads zero", bus_rdata, 8'h00);
    do_reset(1'b1, 1'b1);
    check_cfg("R1 special reset", 8'h06);
  endtask

  task automatic t_window_last;
    do_reset(1'b0, 1'b0);
    idle(40);
    for (int i = 0; i < 10; i++) bus_cyc(1'b0, 1'b0, 6'h00, 8'h00);
    idle(23);
    bus_cyc(1'b1, 1'b1, CFG, 8'hFF);       // bus cycle 63
    check_cfg("R3 write at cycle 63 / R2 unimplemented bits", 8'h06);
  endtask

  task automatic t_window_closed;
    do_reset(1'b0, 1'b0);
    idle(64);
    bus_cyc(1'b1, 1'b1, CFG, 8'h04);       // bus cycle 64
    check_cfg("R4 write at cycle 64 ignored", 8'h02);
    idle(200);
    bus_cyc(1'b1, 1'b1, CFG, 8'h04);
    check_cfg("R9 window stays shut", 8'h02);
  endtask

  task automatic t_once_only;
    do_reset(1'b0, 1'b0);
    bus_cyc(1'b1, 1'b1, 6'h3E, 8'h04);
    check_cfg("R8 other address write", 8'h02);
    bus_cyc(1'b0, 1'b1, CFG, 8'h04);
    check_cfg("R8 write without strobe", 8'h02);
    bus_cyc(1'b1, 1'b0, CFG, 8'h04);
    check_cfg("R8 strobe without write enable", 8'h02);
    bus_cyc(1'b1, 1'b1, CFG, 8'h00);
    check_cfg("R8 no lock from ignored cycles", 8'h00);
    bus_cyc(1'b1, 1'b1, CFG, 8'h06);
    check_cfg("R5 second write ignored", 8'h00);
    do_reset(1'b0, 1'b0);
    bus_cyc(1'b1, 1'b1, CFG, 8'h02);       // same value, still locks
    bus_cyc(1'b1, 1'b1, CFG, 8'h04);
    check_cfg("R5 unchanged write locks", 8'h02);
  endtask

  task automatic t_special;
    do_reset(1'b1, 1'b1);
    bus_cyc(1'b1, 1'b1, CFG, 8'h00);
    check_cfg("R6 special write", 8'h00);
    idle(200);
    bus_cyc(1'b1, 1'b1, CFG, 8'h06);
    check_cfg("R6 special late write", 8'h06);
    bus_cyc(1'b1, 1'b1, CFG, 8'h02);
    check_cfg("R6 special repeat write", 8'h02);
    do_reset(1'b0, 1'b1);
    check_cfg("R6 smode alone reset", 8'h02);
    idle(64);
    bus_cyc(1'b1, 1'b1, CFG, 8'h06);
    check_cfg("R6 smode alone not special", 8'h02);
  endtask

  task automatic t_mode_drop;
    do_reset(1'b1, 1'b1);
    bus_cyc(1'b1, 1'b1, CFG, 8'h00);
    smode_bit = 1'b0;
    bus_cyc(1'b0, 1'b0, 6'h00, 8'h00);
    bus_cyc(1'b1, 1'b1, CFG, 8'h04);
    check_cfg("R7 first normal write after drop", 8'h04);
    bus_cyc(1'b1, 1'b1, CFG, 8'h06);
    check_cfg("R7 second normal write ignored", 8'h04);
    do_reset(1'b1, 1'b1);
    idle(70);
    smode_bit = 1'b0;
    bus_cyc(1'b0, 1'b0, 6'h00, 8'h00);
    bus_cyc(1'b1, 1'b1, CFG, 8'h00);
    check_cfg("R7 drop after window", 8'h06);
  endtask

  initial begin
    t_reset_values();
    t_window_last();
    t_window_closed();
    t_once_only();
    t_special();
    t_mode_drop();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule